// File: doc/BRIEF.md
# Trap Entry and Return Controller

This block handles the two control-flow events at the edge of a processor's exception machinery. A software trap request carries a base and an offset. The block turns them into an 8-bit vector number that always falls in the upper half of the vector space.

A return request carries a one-bit debug selector. The block decides whether the return may proceed. If it may, the block produces the new program counter and the updated processor status.

The block holds the processor status register and the running mode, which is either normal or debug. The status register has three bits: supervisor, previous supervisor and trap enable. The surrounding pipeline supplies the saved program counters and the debug saved-status bits. It loads the status register directly when needed and signals entry into debug mode. All results are registered and appear one cycle after the request.

Top module: `trap_return_ctrl`

## Requirements
- R1: A trap request produces `trap_vec` = ((base + offset) mod 128) + 128 in the following cycle, with `trap_vld` high for that one cycle; bit 7 of the vector is therefore always 1.
- R2: Synchronous active-high reset leaves the block in normal mode (`in_debug`=0) with status {te,prev_sup,sup} = 3'b001 (bit 2 trap enable, bit 1 previous supervisor, bit 0 supervisor) and all pulse outputs low.
- R3: A return while trap enable is 0 raises `halt_pulse` for one cycle and leaves the status, the mode and `pc_vld` unchanged.
- R4: A return with trap enable 1 and supervisor 0 raises `illegal_pulse` for one cycle and changes neither status nor mode.
- R5: In normal mode, a return with selector 0 (and te=1, sup=1) gives `pc_out` = normal saved PC with `pc_vld`, and copies the previous-supervisor bit into the supervisor bit; te and prev_sup are kept.
- R6: In debug mode, a return with selector 1 (and te=1, sup=1) gives `pc_out` = debug saved PC with `pc_vld`, loads te and sup from the debug saved bits, keeps prev_sup, leaves debug mode and pulses `mode_chg`.
- R7: A return whose selector does not match the mode (normal with 1, debug with 0) changes nothing and raises no pulse.
- R8: The status update and the one-cycle `pc_vld` appear in the cycle after the return request; at most one of `halt_pulse`, `illegal_pulse` and `pc_vld` is high in any cycle.
- R9: `stat_load` writes `stat_wdata` into the status register in the next cycle, unless a return is requested in the same cycle, in which case the write is ignored.
- R10: `dbg_enter` switches to debug mode with a one-cycle `mode_chg` pulse; it is ignored with no pulse when a return is requested in the same cycle or the block is already in debug mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Software trap request |
| trap_base | input | VAL_W | Trap base operand |
| trap_offset | input | VAL_W | Trap offset operand |
| ret_req | input | 1 | Return-from-trap request |
| ret_dbg_field | input | 1 | Return selector: 0 normal return, 1 debug return |
| pc_save_norm | input | PC_W | Saved PC for normal-mode return |
| pc_save_dbg | input | PC_W | Saved PC for debug-mode return |
| dbg_save_te | input | 1 | Debug saved trap-enable bit |
| dbg_save_sup | input | 1 | Debug saved supervisor bit |
| stat_load | input | 1 | Load status register |
| stat_wdata | input | 3 | Status value to load |
| dbg_enter | input | 1 | Enter debug mode |
| trap_vld | output | 1 | Trap vector valid pulse |
| trap_vec | output | 8 | Trap vector number |
| pc_vld | output | 1 | New PC valid pulse |
| pc_out | output | PC_W | New program counter |
| stat_out | output | 3 | Current status register |
| in_debug | output | 1 | 1 while in debug mode |
| mode_chg | output | 1 | Mode change pulse |
| halt_pulse | output | 1 | Return attempted with traps disabled |
| illegal_pulse | output | 1 | Return attempted outside supervisor |

## Verification
The assertions watch on every cycle that a vector always has its top bit set. They also check that a halt or illegal outcome leaves the status and the mode untouched and that `pc_vld` only follows a return request. Further per-cycle checks are that the three outcome pulses are mutually exclusive and that a debug return always drops the mode. What only the bench scenarios can show is the value side of each outcome. That covers the vector arithmetic with wrap and negative offsets, and which saved PC and which saved bits were chosen. It also covers the precedence of returns over status loads and debug entry, and the silent mismatch cases.

// File: rtl/trp_pkg.sv
package trp_pkg;

  typedef struct packed {
    logic te;
    logic prev_sup;
    logic sup;
  } stat_t;

  typedef enum logic [2:0] {
    RET_NONE    = 3'd0,
    RET_HALT    = 3'd1,
    RET_ILLEGAL = 3'd2,
    RET_NORMAL  = 3'd3,
    RET_DEBUG   = 3'd4
  } ret_kind_t;

  // Vector: low seven bits of the sum, placed in the upper half.
  function automatic logic [7:0] vec_of(input logic [6:0] b, input logic [6:0] o);
    logic [6:0] s;
    s = b + o;
    return {1'b1, s};
  endfunction

  // Priority: trap enable, then supervisor, then mode/selector match.
  function automatic ret_kind_t classify(input stat_t st, input logic dbg_mode,
                                         input logic sel);
    if (!st.te)                 return RET_HALT;
    else if (!st.sup)           return RET_ILLEGAL;
    else if (!dbg_mode && !sel) return RET_NORMAL;
    else if (dbg_mode && sel)   return RET_DEBUG;
    else                        return RET_NONE;
  endfunction

endpackage

// File: rtl/trp_vector_unit.sv
module trp_vector_unit #(
  parameter int VAL_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [VAL_W-1:0] base,
  input  logic [VAL_W-1:0] offset,
  output logic             vld,
  output logic [7:0]       vec
);
  import trp_pkg::*;

  logic [7:0] vec_next;
  assign vec_next = vec_of(base[6:0], offset[6:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
      vec <= 8'h80;
    end else begin
      vld <= req;
      if (req) vec <= vec_next;
    end
  end

  assert_vec_high_R1: assert property (@(posedge clk) disable iff (rst)
    vld |-> vec[7]);

endmodule

// File: rtl/trp_return_decide.sv
module trp_return_decide (
  input  trp_pkg::stat_t    st,
  input  logic              dbg_mode,
  input  logic              sel,
  input  logic              dbg_te,
  input  logic              dbg_sup,
  output trp_pkg::ret_kind_t kind,
  output trp_pkg::stat_t    st_next
);
  import trp_pkg::*;

  always_comb begin
    kind    = classify(st, dbg_mode, sel);
    st_next = st;
    case (kind)
      RET_NORMAL: st_next.sup = st.prev_sup;
      RET_DEBUG: begin
        st_next.te  = dbg_te;
        st_next.sup = dbg_sup;
      end
      default: st_next = st;
    endcase
  end

endmodule

// File: rtl/trap_return_ctrl.sv
module trap_return_ctrl #(
  parameter int VAL_W = 32,
  parameter int PC_W  = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trap_req,
  input  logic [VAL_W-1:0] trap_base,
  input  logic [VAL_W-1:0] trap_offset,
  input  logic            ret_req,
  input  logic            ret_dbg_field,
  input  logic [PC_W-1:0] pc_save_norm,
  input  logic [PC_W-1:0] pc_save_dbg,
  input  logic            dbg_save_te,
  input  logic            dbg_save_sup,
  input  logic            stat_load,
  input  logic [2:0]      stat_wdata,
  input  logic            dbg_enter,
  output logic            trap_vld,
  output logic [7:0]      trap_vec,
  output logic            pc_vld,
  output logic [PC_W-1:0] pc_out,
  output logic [2:0]      stat_out,
  output logic            in_debug,
  output logic            mode_chg,
  output logic            halt_pulse,
  output logic            illegal_pulse
);
  import trp_pkg::*;

  localparam stat_t STAT_RST = '{te: 1'b0, prev_sup: 1'b0, sup: 1'b1};

  stat_t     stat_q;
  logic      dbg_q;
  ret_kind_t kind;
  stat_t     st_ret;

  // Named internal events for the assertions.
  logic ev_ret_ok;
  logic ev_dbg_exit;
  logic ev_dbg_enter;
  logic ev_load;

  trp_vector_unit #(.VAL_W(VAL_W)) u_vec (
    .clk(clk), .rst(rst), .req(trap_req), .base(trap_base),
    .offset(trap_offset), .vld(trap_vld), .vec(trap_vec)
  );

  trp_return_decide u_dec (
    .st(stat_q), .dbg_mode(dbg_q), .sel(ret_dbg_field),
    .dbg_te(dbg_save_te), .dbg_sup(dbg_save_sup),
    .kind(kind), .st_next(st_ret)
  );

  assign ev_ret_ok    = ret_req && (kind == RET_NORMAL || kind == RET_DEBUG);
  assign ev_dbg_exit  = ret_req && (kind == RET_DEBUG);
  assign ev_dbg_enter = !ret_req && dbg_enter && !dbg_q;
  assign ev_load      = !ret_req && stat_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q        <= STAT_RST;
      dbg_q         <= 1'b0;
      pc_vld        <= 1'b0;
      pc_out        <= '0;
      mode_chg      <= 1'b0;
      halt_pulse    <= 1'b0;
      illegal_pulse <= 1'b0;
    end else begin
      pc_vld        <= ev_ret_ok;
      halt_pulse    <= ret_req && (kind == RET_HALT);
      illegal_pulse <= ret_req && (kind == RET_ILLEGAL);
      mode_chg      <= ev_dbg_exit || ev_dbg_enter;
      if (ret_req) begin
        stat_q <= st_ret;
        if (kind == RET_NORMAL) pc_out <= pc_save_norm;
        if (kind == RET_DEBUG)  pc_out <= pc_save_dbg;
        if (kind == RET_DEBUG)  dbg_q  <= 1'b0;
      end else begin
        if (ev_load)      stat_q <= stat_t'(stat_wdata);
        if (ev_dbg_enter) dbg_q  <= 1'b1;
      end
    end
  end

  assign stat_out = stat_q;
  assign in_debug = dbg_q;

  assert_halt_hold_R3: assert property (@(posedge clk) disable iff (rst)
    halt_pulse |-> (!pc_vld && stat_q == $past(stat_q) && dbg_q == $past(dbg_q)));

  assert_illegal_hold_R4: assert property (@(posedge clk) disable iff (rst)
    illegal_pulse |-> (stat_q == $past(stat_q) && dbg_q == $past(dbg_q)));

  assert_dbg_exit_R6: assert property (@(posedge clk) disable iff (rst)
    (pc_vld && $past(dbg_q)) |-> (!dbg_q && mode_chg));

  assert_excl_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({halt_pulse, illegal_pulse, pc_vld}));

  assert_vld_after_req_R8: assert property (@(posedge clk) disable iff (rst)
    (pc_vld || halt_pulse || illegal_pulse) |-> $past(ret_req));

  assert_enter_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    ev_dbg_enter |=> (dbg_q && mode_chg));

endmodule

// File: tb/sim_trap_return_ctrl.sv
module sim_trap_return_ctrl;
  localparam int PERIOD = 10;
  localparam int VW = 32;
  localparam int PW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trap_req = 0, ret_req = 0, ret_dbg_field = 0;
  logic [VW-1:0] trap_base = 0, trap_offset = 0;
  logic [PW-1:0] pc_save_norm = 0, pc_save_dbg = 0;
  logic dbg_save_te = 0, dbg_save_sup = 0, stat_load = 0, dbg_enter = 0;
  logic [2:0] stat_wdata = 0;
  logic trap_vld, pc_vld, in_debug, mode_chg, halt_pulse, illegal_pulse;
  logic [7:0] trap_vec;
  logic [PW-1:0] pc_out;
  logic [2:0] stat_out;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // model state
  logic [2:0] m_stat;
  logic m_dbg;

  always #(PERIOD/2) clk = ~clk;

  trap_return_ctrl #(.VAL_W(VW), .PC_W(PW)) u0 (
    .clk(clk), .rst(rst), .trap_req(trap_req), .trap_base(trap_base),
    .trap_offset(trap_offset), .ret_req(ret_req), .ret_dbg_field(ret_dbg_field),
    .pc_save_norm(pc_save_norm), .pc_save_dbg(pc_save_dbg),
    .dbg_save_te(dbg_save_te), .dbg_save_sup(dbg_save_sup),
    .stat_load(stat_load), .stat_wdata(stat_wdata), .dbg_enter(dbg_enter),
    .trap_vld(trap_vld), .trap_vec(trap_vec), .pc_vld(pc_vld), .pc_out(pc_out),
    .stat_out(stat_out), .in_debug(in_debug), .mode_chg(mode_chg),
    .halt_pulse(halt_pulse), .illegal_pulse(illegal_pulse)
  );

  function automatic logic [7:0] exp_vec(input logic [31:0] b, input logic [31:0] o);
    int unsigned s;
    s = (b + o) % 128;
    return 8'(s + 128);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Apply current inputs for one edge and compare against the model.
  task automatic step();
    logic e_tv, e_pv, e_mc, e_h, e_i;
    logic [7:0] e_vec;
    logic [31:0] e_pc;
    string tag;
    e_tv = trap_req;
    e_vec = exp_vec(trap_base, trap_offset);
    e_pv = 0; e_mc = 0; e_h = 0; e_i = 0; e_pc = 0;
    tag = "R9";
    if (ret_req) begin
      if (!m_stat[2]) begin e_h = 1; tag = "R3"; end
      else if (!m_stat[0]) begin e_i = 1; tag = "R4"; end
      else if (!m_dbg && !ret_dbg_field) begin
        e_pv = 1; e_pc = pc_save_norm; m_stat[0] = m_stat[1]; tag = "R5";
      end else if (m_dbg && ret_dbg_field) begin
        e_pv = 1; e_pc = pc_save_dbg; m_stat[2] = dbg_save_te;
        m_stat[0] = dbg_save_sup; m_dbg = 0; e_mc = 1; tag = "R6";
      end else tag = "R7";
    end else begin
      if (stat_load) m_stat = stat_wdata;
      if (dbg_enter && !m_dbg) begin m_dbg = 1; e_mc = 1; tag = "R10"; end
    end
    @(posedge clk); #1;
    chk("R1 trap_vld", trap_vld, e_tv);
    if (e_tv) chk("R1 trap_vec", trap_vec, e_vec);
    chk({tag, " R8 pc_vld"}, pc_vld, e_pv);
    if (e_pv) chk({tag, " pc_out"}, pc_out, e_pc);
    chk({tag, " stat"}, stat_out, m_stat);
    chk({tag, " mode"}, in_debug, m_dbg);
    chk({tag, " mode_chg"}, mode_chg, e_mc);
    chk("R3 halt", halt_pulse, e_h);
    chk("R4 illegal", illegal_pulse, e_i);
  endtask

  task automatic idle();
    trap_req = 0; ret_req = 0; stat_load = 0; dbg_enter = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R2 reset state
    m_stat = 3'b001; m_dbg = 0;
    chk("R2 stat", stat_out, 3'b001);
    chk("R2 mode", in_debug, 0);
    chk("R2 pulses", {trap_vld, pc_vld, mode_chg, halt_pulse, illegal_pulse}, 0);

    // R1 corner cases: wrap, all ones, negative offset
    trap_req = 1; trap_base = 32'h7F; trap_offset = 1; step();
    chk("R1 wrap to 0x80", trap_vec, 8'h80);
    trap_base = 32'hFFFF_FFFF; trap_offset = 0; step();
    chk("R1 max 0xFF", trap_vec, 8'hFF);
    trap_base = 0; trap_offset = 32'hFFFF_FFFF; step();
    chk("R1 negative offset", trap_vec, 8'hFF);
    idle();

    // R3 return at reset state (te=0)
    ret_req = 1; pc_save_norm = 32'h1000; step(); idle();
    // R4 te=1 sup=0
    stat_load = 1; stat_wdata = 3'b110; step(); idle();
    ret_req = 1; step(); idle();
    // R5 normal return, prev=0 -> sup becomes 0
    stat_load = 1; stat_wdata = 3'b101; step(); idle();
    ret_req = 1; ret_dbg_field = 0; pc_save_norm = 32'hCAFE_0000; step(); idle();
    chk("R5 sup from prev", stat_out, 3'b100);
    // R7 normal with selector 1
    stat_load = 1; stat_wdata = 3'b111; step(); idle();
    ret_req = 1; ret_dbg_field = 1; step(); idle();
    // R10 enter debug, R7 debug with selector 0, R9 load ignored with return
    dbg_enter = 1; step(); idle();
    ret_req = 1; ret_dbg_field = 0; stat_load = 1; stat_wdata = 3'b000; step(); idle();
    chk("R9 load ignored", stat_out, 3'b111);
    // R10 enter while already in debug: no pulse
    dbg_enter = 1; step(); idle();
    // R6 debug return
    ret_req = 1; ret_dbg_field = 1; pc_save_dbg = 32'hBEEF_0004;
    dbg_save_te = 0; dbg_save_sup = 1; step(); idle();
    chk("R6 left debug", in_debug, 0);
    // R10 enter ignored with return
    stat_load = 1; stat_wdata = 3'b111; step(); idle();
    ret_req = 1; ret_dbg_field = 1; dbg_enter = 1; step(); idle();

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      trap_req      = ($urandom % 3) == 0;
      trap_base     = $urandom;
      trap_offset   = $urandom;
      ret_req       = ($urandom % 3) == 0;
      ret_dbg_field = $urandom % 2;
      pc_save_norm  = $urandom;
      pc_save_dbg   = $urandom;
      dbg_save_te   = ($urandom % 4) != 0;
      dbg_save_sup  = ($urandom % 4) != 0;
      stat_load     = ($urandom % 4) == 0;
      stat_wdata    = (($urandom % 4) != 0) ? 3'($urandom | 5) : 3'($urandom);
      dbg_enter     = ($urandom % 6) == 0;
      step();
    end
    idle();
    step();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule